// File: doc/BRIEF.md
# Dual-Buffer Sequential Access Memory

This block is a word-addressed storage array with two independent access paths. The random side presents a plain SRAM-style interface. It takes an explicit address, a write strobe and per-byte write lanes, and it can also reach a small bank of configuration registers. The sequential side never sees an address. Each access it makes uses an internal pointer, and after every access that pointer moves to the next word.

The pointer runs through two programmable regions, A and B, each bounded by a head and a tail register. After an access at the tail of A the pointer jumps to the head of B. After an access at the tail of B it returns to the head of A, so the two regions act as a ping-pong buffer. A sticky flag per region records that its tail was reached, which lets a producer or consumer on the random side hand buffers back and forth. Both paths run on one clock. The global reset is asserted asynchronously and released synchronously. The default address width gives 1024 words; setting `AW` to 13 gives the full 8K x 16 array.

Top module: `sabuf_top`

## Requirements
- R1: A random write (`ra_cs`=1, `ra_we`=1, `ra_cfg`=0, both `ra_be` bits set) stores `ra_wdata` at `ra_addr`. A random read (`ra_cs`=1, `ra_we`=0, `ra_cfg`=0) returns that word on `ra_rdata` one clock later.
- R2: On a random write, `ra_be[0]` gates bits 7:0 and `ra_be[1]` gates bits 15:8. A lane whose enable is clear keeps its old contents.
- R3: With `ra_cfg`=1, `ra_addr[1:0]` selects a configuration register: 0 head A, 1 tail A, 2 head B, 3 tail B. A write loads `ra_wdata[AW-1:0]`, and a read returns the value zero-extended one clock later. After reset the registers hold 0, DEPTH/2-1, DEPTH/2 and DEPTH-1.
- R4: After the global reset, `sq_ptr` is 0 (head A), both flags are 0 and `ra_rdata` is 0.
- R5: A `sq_rst` pulse loads `sq_ptr` with head A on the next clock and clears both flags. It performs no memory access and leaves the configuration registers unchanged.
- R6: A sequential read (`sq_en`=1, `sq_we`=0) returns the word at the current pointer on `sq_rdata` one clock later.
- R7: Each sequential access at an address that is neither tail moves the pointer to address+1, modulo DEPTH.
- R8: An access at tail A loads head B into the pointer. An access at tail B, when it is not also tail A, loads head A.
- R9: An access at tail A sets `flag_a`, and an access at tail B sets `flag_b`, visible on the next clock.
- R10: A flag stays set until a configuration write or `sq_rst`, either of which clears both flags on the next clock.
- R11: When both sides write the same word in one clock, each byte lane enabled on the random side takes the random data. The other lanes take the sequential data.
- R12: With `sq_en`=0 the pointer and flags hold, and a raised `sq_we` writes nothing.
- R13: A sequential write (`sq_en`=1, `sq_we`=1) stores the whole `sq_wdata` word at the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both access paths |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| ra_cs | input | 1 | Random-side access request |
| ra_we | input | 1 | Random-side write (1) or read (0) |
| ra_cfg | input | 1 | Random access targets configuration registers |
| ra_be | input | DW/8 | Random-side byte-lane write enables |
| ra_addr | input | AW | Random-side word address or register index |
| ra_wdata | input | DW | Random-side write data |
| ra_rdata | output | DW | Random-side read data, one clock after request |
| sq_en | input | 1 | Sequential access and pointer advance |
| sq_we | input | 1 | Sequential write (1) or read (0) |
| sq_rst | input | 1 | Reload pointer with head A and clear flags |
| sq_wdata | input | DW | Sequential write data |
| sq_rdata | output | DW | Sequential read data, one clock after access |
| sq_ptr | output | AW | Current sequential pointer |
| flag_a | output | 1 | Tail of region A reached |
| flag_b | output | 1 | Tail of region B reached |

## Verification
The assertions check the pointer control and the register bank on every clock. They cover the hold when idle, the jump from tail A to head B, the reload on `sq_rst`, flag setting, flag persistence, flag clearing, and the landing of configuration writes. The stored data is checked only by the bench's scenarios. Those scenarios cover byte-lane masking, the per-lane merge when both sides write the same word, and the one-clock read latency on both sides. The full wrap through both regions and the flags seen from outside are also shown by scenario.

// File: rtl/sabuf_pkg.sv
package sabuf_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    CFG_HEAD_A = 2'd0,
    CFG_TAIL_A = 2'd1,
    CFG_HEAD_B = 2'd2,
    CFG_TAIL_B = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/sabuf_cfg.sv
module sabuf_cfg
  import sabuf_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] head_a,
  output logic [AW-1:0] tail_a,
  output logic [AW-1:0] head_b,
  output logic [AW-1:0] tail_b,
  output logic [AW-1:0] rd_val
);
  localparam logic [AW-1:0] HALF = {1'b1, {(AW-1){1'b0}}};
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic [AW-1:0] regs_q [4];
  logic [AW-1:0] regs_d [4];

  function automatic logic [AW-1:0] reset_val(input int idx);
    case (idx)
      0:       return '0;
      1:       return HALF - 1'b1;
      2:       return HALF;
      default: return LAST;
    endcase
  endfunction

  always_comb begin
    for (int i = 0; i < 4; i++) regs_d[i] = regs_q[i];
    regs_d[sel] = wdata;
  end

  for (genvar g = 0; g < 4; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[g] <= reset_val(g);
      else if (wr)
        regs_q[g] <= regs_d[g];
    end
  end

  assign head_a = regs_q[CFG_HEAD_A];
  assign tail_a = regs_q[CFG_TAIL_A];
  assign head_b = regs_q[CFG_HEAD_B];
  assign tail_b = regs_q[CFG_TAIL_B];

  always_comb begin
    case (cfg_sel_e'(sel))
      CFG_HEAD_A: rd_val = head_a;
      CFG_TAIL_A: rd_val = tail_a;
      CFG_HEAD_B: rd_val = head_b;
      default:    rd_val = tail_b;
    endcase
  end

  // R3
  cfg_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> regs_q[$past(sel)] == $past(wdata));
endmodule

// File: rtl/sabuf_ptr.sv
module sabuf_ptr #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          sq_rst,
  input  logic          cfg_wr,
  input  logic [AW-1:0] head_a,
  input  logic [AW-1:0] tail_a,
  input  logic [AW-1:0] head_b,
  input  logic [AW-1:0] tail_b,
  output logic [AW-1:0] ptr,
  output logic          flag_a,
  output logic          flag_b
);
  logic [AW-1:0] ptr_q, ptr_d;
  logic          fa_q, fa_d, fb_q, fb_d;
  logic          hit_a, hit_b, clr;

  assign hit_a = (ptr_q == tail_a);
  assign hit_b = !hit_a && (ptr_q == tail_b);
  assign clr   = sq_rst || cfg_wr;

  always_comb begin
    ptr_d = ptr_q;
    if (sq_rst)
      ptr_d = head_a;
    else if (adv) begin
      if (hit_a)      ptr_d = head_b;
      else if (hit_b) ptr_d = head_a;
      else            ptr_d = ptr_q + 1'b1;
    end
  end

  always_comb begin
    fa_d = fa_q;
    fb_d = fb_q;
    if (clr) begin
      fa_d = 1'b0;
      fb_d = 1'b0;
    end else if (adv) begin
      if (hit_a) fa_d = 1'b1;
      if (hit_b) fb_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (adv || sq_rst)
      ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa_q <= 1'b0;
      fb_q <= 1'b0;
    end else if (adv || clr) begin
      fa_q <= fa_d;
      fb_q <= fb_d;
    end
  end

  assign ptr    = ptr_q;
  assign flag_a = fa_q;
  assign flag_b = fb_q;

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> ($stable(ptr_q) && $stable(fa_q) && $stable(fb_q)));
  // R8
  tail_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !sq_rst && ptr_q == tail_a) |=> ptr_q == $past(head_b));
  // R5
  seq_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_rst |=> ptr_q == $past(head_a));
  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && ptr_q == tail_a) |=> flag_a);
  // R10
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_q && !clr) |=> fb_q);
  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!fa_q && !fb_q));
endmodule

// File: rtl/sabuf_mem.sv
module sabuf_mem
  import sabuf_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        ra_addr,
  input  logic                 ra_wr,
  input  logic                 ra_rd,
  input  logic [DW/LANE_W-1:0] ra_be,
  input  logic [DW-1:0]        ra_wdata,
  output logic [DW-1:0]        ra_rdata,
  input  logic [AW-1:0]        sq_addr,
  input  logic                 sq_wr,
  input  logic                 sq_rd,
  input  logic [DW-1:0]        sq_wdata,
  output logic [DW-1:0]        sq_rdata
);
  localparam int NB    = DW / LANE_W;
  localparam int DEPTH = 1 << AW;

  logic same_word;
  assign same_word = (ra_addr == sq_addr);

  for (genvar l = 0; l < NB; l++) begin : g_lane
    logic [LANE_W-1:0] arr [DEPTH];
    logic [LANE_W-1:0] ra_q, sq_q;
    logic              ra_lwr, sq_lwr;

    assign ra_lwr = ra_wr && ra_be[l];
    assign sq_lwr = sq_wr && !(ra_lwr && same_word);

    always_ff @(posedge clk) begin
      if (ra_lwr) arr[ra_addr] <= ra_wdata[l*LANE_W +: LANE_W];
      if (sq_lwr) arr[sq_addr] <= sq_wdata[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ra_q <= '0;
        sq_q <= '0;
      end else begin
        if (ra_rd) ra_q <= arr[ra_addr];
        if (sq_rd) sq_q <= arr[sq_addr];
      end
    end

    assign ra_rdata[l*LANE_W +: LANE_W] = ra_q;
    assign sq_rdata[l*LANE_W +: LANE_W] = sq_q;
  end
endmodule

// File: rtl/sabuf_top.sv
module sabuf_top
  import sabuf_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ra_cs,
  input  logic                 ra_we,
  input  logic                 ra_cfg,
  input  logic [DW/LANE_W-1:0] ra_be,
  input  logic [AW-1:0]        ra_addr,
  input  logic [DW-1:0]        ra_wdata,
  output logic [DW-1:0]        ra_rdata,
  input  logic                 sq_en,
  input  logic                 sq_we,
  input  logic                 sq_rst,
  input  logic [DW-1:0]        sq_wdata,
  output logic [DW-1:0]        sq_rdata,
  output logic [AW-1:0]        sq_ptr,
  output logic                 flag_a,
  output logic                 flag_b
);
  localparam int PADW = DW - AW;

  logic [1:0]    rs_q;
  logic          rst_i_n;
  logic          mem_wr, mem_rd, cfg_wr, cfg_rd, sq_go;
  logic [AW-1:0] head_a, tail_a, head_b, tail_b, cfg_val;
  logic [AW-1:0] cfg_q;
  logic          cfg_sel_q;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  assign mem_wr = ra_cs &&  ra_we && !ra_cfg;
  assign mem_rd = ra_cs && !ra_we && !ra_cfg;
  assign cfg_wr = ra_cs &&  ra_we &&  ra_cfg;
  assign cfg_rd = ra_cs && !ra_we &&  ra_cfg;
  assign sq_go  = sq_en && !sq_rst;

  sabuf_cfg #(.AW(AW)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .wr     (cfg_wr),
    .sel    (ra_addr[1:0]),
    .wdata  (ra_wdata[AW-1:0]),
    .head_a (head_a),
    .tail_a (tail_a),
    .head_b (head_b),
    .tail_b (tail_b),
    .rd_val (cfg_val)
  );

  sabuf_ptr #(.AW(AW)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .adv    (sq_go),
    .sq_rst (sq_rst),
    .cfg_wr (cfg_wr),
    .head_a (head_a),
    .tail_a (tail_a),
    .head_b (head_b),
    .tail_b (tail_b),
    .ptr    (ptr),
    .flag_a (flag_a),
    .flag_b (flag_b)
  );

  sabuf_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .ra_addr  (ra_addr),
    .ra_wr    (mem_wr),
    .ra_rd    (mem_rd),
    .ra_be    (ra_be),
    .ra_wdata (ra_wdata),
    .ra_rdata (mem_rdata),
    .sq_addr  (ptr),
    .sq_wr    (sq_go && sq_we),
    .sq_rd    (sq_go && !sq_we),
    .sq_wdata (sq_wdata),
    .sq_rdata (sq_rdata)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cfg_q     <= '0;
      cfg_sel_q <= 1'b0;
    end else begin
      if (cfg_rd) cfg_q <= cfg_val;
      if (cfg_rd || mem_rd) cfg_sel_q <= cfg_rd;
    end
  end

  assign ra_rdata = cfg_sel_q ? {{PADW{1'b0}}, cfg_q} : mem_rdata;
  assign sq_ptr   = ptr;
endmodule

// File: tb/sim_sabuf_top.sv
module sim_sabuf_top;
  localparam int AW    = 10;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ra_cs, ra_we, ra_cfg;
  logic [1:0]    ra_be;
  logic [AW-1:0] ra_addr;
  logic [DW-1:0] ra_wdata, ra_rdata;
  logic          sq_en, sq_we, sq_rst;
  logic [DW-1:0] sq_wdata, sq_rdata;
  logic [AW-1:0] sq_ptr;
  logic          flag_a, flag_b;

  always #2 clk = ~clk;

  sabuf_top #(.AW(AW), .DW(DW)) u0 (.*);

  typedef struct { int kind; logic [15:0] exp; string tag; } item_t;
  item_t sb[$];
  int total = 0, bad = 0;
  bit done = 0;

  logic [15:0] bmem [int];
  int cfg [4];
  int bptr;
  bit bfa, bfb;

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = ra_rdata;
        1: act = sq_rdata;
        2: act = 16'(sq_ptr);
        3: act = {15'd0, flag_a};
        default: act = {15'd0, flag_b};
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  function automatic void push(int k, logic [15:0] e, string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    sb.push_back(it);
  endfunction

  function automatic void push_state(string t);
    push(2, 16'(bptr), t);
    push(3, {15'd0, bfa}, t);
    push(4, {15'd0, bfb}, t);
  endfunction

  task automatic idle_in();
    ra_cs = 0; ra_we = 0; ra_cfg = 0; ra_be = 2'b00; ra_addr = '0; ra_wdata = '0;
    sq_en = 0; sq_we = 0; sq_rst = 0; sq_wdata = '0;
  endtask

  task automatic ra_write(int a, logic [15:0] d, logic [1:0] be, bit reg_sel);
    @(negedge clk);
    ra_cs = 1; ra_we = 1; ra_cfg = reg_sel; ra_addr = AW'(a); ra_wdata = d; ra_be = be;
    @(posedge clk); #1; idle_in();
    if (reg_sel) begin
      cfg[a % 4] = d[AW-1:0]; bfa = 0; bfb = 0;
    end else begin
      logic [15:0] o;
      o = bmem.exists(a) ? bmem[a] : 16'h0000;
      if (be[0]) o[7:0] = d[7:0];
      if (be[1]) o[15:8] = d[15:8];
      bmem[a] = o;
    end
  endtask

  task automatic ra_read(int a, bit reg_sel, string t);
    @(negedge clk);
    ra_cs = 1; ra_we = 0; ra_cfg = reg_sel; ra_addr = AW'(a);
    @(posedge clk); #1; idle_in();
    push(0, reg_sel ? 16'(cfg[a % 4]) : bmem[a], t);
  endtask

  task automatic sq_step(bit we, logic [15:0] wd, bit co, logic [15:0] rwd, logic [1:0] rbe, string t);
    bit ja, jb;
    @(negedge clk);
    sq_en = 1; sq_we = we; sq_wdata = wd;
    if (co) begin ra_cs = 1; ra_we = 1; ra_addr = AW'(bptr); ra_wdata = rwd; ra_be = rbe; end
    @(posedge clk); #1; idle_in();
    if (!we) push(1, bmem[bptr], t);
    else begin
      logic [15:0] w;
      w = wd;
      if (co && rbe[0]) w[7:0] = rwd[7:0];
      if (co && rbe[1]) w[15:8] = rwd[15:8];
      bmem[bptr] = w;
    end
    ja = (bptr == cfg[1]);
    jb = !ja && (bptr == cfg[3]);
    if (ja) begin bptr = cfg[2]; bfa = 1; end
    else if (jb) begin bptr = cfg[0]; bfb = 1; end
    else bptr = (bptr + 1) % DEPTH;
    if (ja || jb) begin push(2, 16'(bptr), "R8"); push(3, {15'd0, bfa}, "R9"); push(4, {15'd0, bfb}, "R9"); end
    else begin push(2, 16'(bptr), "R7"); push(3, {15'd0, bfa}, "R10"); push(4, {15'd0, bfb}, "R10"); end
  endtask

  task automatic sq_idle(bit we);
    @(negedge clk);
    sq_en = 0; sq_we = we; sq_wdata = 16'hDEAD;
    @(posedge clk); #1; idle_in();
    push_state("R12");
  endtask

  task automatic seq_reset();
    @(negedge clk);
    sq_rst = 1; sq_en = 1;
    @(posedge clk); #1; idle_in();
    bptr = cfg[0]; bfa = 0; bfb = 0;
    push_state("R5");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle_in();
    cfg[0] = 0; cfg[1] = DEPTH/2 - 1; cfg[2] = DEPTH/2; cfg[3] = DEPTH - 1;
    bptr = 0; bfa = 0; bfb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    push_state("R4");
    push(0, 16'h0000, "R4");
    ra_read(1, 1, "R3");
    ra_read(3, 1, "R3");
    // R3: program regions A = 10..13, B = 100..101
    ra_write(0, 16'd10, 2'b11, 1);
    ra_write(1, 16'd13, 2'b11, 1);
    ra_write(2, 16'd100, 2'b11, 1);
    ra_write(3, 16'd101, 2'b11, 1);
    ra_read(2, 1, "R3");
    seq_reset();
    // R1
    ra_write(10, 16'h1111, 2'b11, 0);
    ra_write(11, 16'h2222, 2'b11, 0);
    ra_write(12, 16'h3333, 2'b11, 0);
    ra_write(13, 16'h4444, 2'b11, 0);
    ra_write(100, 16'h5555, 2'b11, 0);
    ra_write(101, 16'h6666, 2'b11, 0);
    ra_read(12, 0, "R1");
    // R6 R7 R8 R9: walk both regions and wrap
    for (int i = 0; i < 7; i++) sq_step(0, 16'h0, 0, 16'h0, 2'b00, "R6");
    // R12
    sq_idle(1);
    sq_idle(0);
    ra_read(11, 0, "R12");
    // R2
    ra_write(11, 16'hAAAA, 2'b01, 0);
    ra_read(11, 0, "R2");
    ra_write(12, 16'hBBBB, 2'b10, 0);
    ra_read(12, 0, "R2");
    // R13
    sq_step(1, 16'h7777, 0, 16'h0, 2'b00, "R13");
    ra_read(11, 0, "R13");
    // R11
    sq_step(1, 16'h1234, 1, 16'hBEEF, 2'b10, "R11");
    ra_read(12, 0, "R11");
    sq_step(1, 16'h5678, 1, 16'hCAFE, 2'b01, "R11");
    ra_read(13, 0, "R11");
    // R10: configuration write clears flags
    ra_write(1, 16'd13, 2'b11, 1);
    @(negedge clk); push_state("R10");
    sq_step(0, 16'h0, 0, 16'h0, 2'b00, "R6");
    sq_step(0, 16'h0, 0, 16'h0, 2'b00, "R6");
    sq_step(0, 16'h0, 0, 16'h0, 2'b00, "R6");
    // R5: mid-buffer reload, configuration untouched
    seq_reset();
    ra_read(0, 1, "R5");
    ra_read(2, 1, "R5");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule